// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This block is the status side of a parallel NOR flash device's embedded write engine. It watches the host's write strobes and the low command byte on the data bus. When it sees a complete unlock-and-command sequence, it starts an embedded program or a sector erase. While that operation runs, reads do not return stored data. They return status bits instead: a data-polling bit on bit 7, an operation toggle bit on bit 6 and a sector toggle bit on bit 2. An active-low busy indication comes out on `ready`.

A running sector erase can be suspended. While it is suspended, the host may read and may start a program outside the suspended sector. A later resume command continues the erase from where it stopped. The memory array is modelled by a single byte register that holds the last completed result. A finished program stores its data byte there, and a finished erase stores the erased value 0xFF. Operation lengths are counted in clock cycles and set by parameters. The tri-state pad drivers are outside the block.

All strobes are active low and are sampled on `clk`. A write pulse is a rising edge of `we_n` while `ce_n` is low. A read cycle is a falling edge of `oe_n` while `ce_n` is low. The status output is combinational from the state and the address being read. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `flash_status_poller`

## Requirements
- R1: While `rst_n` is low, `ready` reads 0. After reset, the block is in read mode with `ready` = 1 and the result byte at 0xFF.
- R2: A program starts only on the sequence 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then a data byte at the target address. `ready` goes low in the cycle after the 4th write pulse is detected and stays high before it.
- R3: During a program, a read returns the inverse of data bit 7 on bit 7 and 1 on bit 2. After completion, a read returns the programmed byte.
- R4: During a program or an erase, bit 6 changes value on every successive read cycle.
- R5: A sector erase starts only on 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the target sector (sector = `addr[11:10]`). `ready` goes low after the 6th pulse and not before. During the erase, bit 7 reads 0.
- R6: During an erase, bit 2 toggles on successive reads of the erasing sector and reads 1 for any other sector.
- R7: While `ready` is low in a program, full program or erase sequences are ignored. The pending program completes with its own data and no new operation starts.
- R8: Writing 0xB0 during an erase suspends it and `ready` returns to 1. Reads of the suspended sector then give bit 7 = 1, bit 6 = 1 (not toggling) and a toggling bit 2. Reads of other sectors return the result byte.
- R9: A program issued while suspended drives `ready` low. Reading its target (outside the suspended sector) gives the inverse of data bit 7 and bit 2 = 1. On completion the block returns to suspend-read with the new byte stored.
- R10: Writing 0x30 while suspended, with no sequence in progress, resumes the erase. `ready` goes low until the remaining erase cycles finish, and afterwards the result byte reads 0xFF.
- R11: A wrong address/data pair at any step of a sequence aborts it back to the first step without raising busy. Any following write must begin a fresh sequence.
- R12: Commands are decoded from `din[7:0]` only, and `din[15:8]` has no effect.
- R13: An uninterrupted program holds `ready` low for exactly `PROG_LEN` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; forces busy |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; rising edge is a write pulse |
| oe_n | input | 1 | Output enable, active low; falling edge is a read cycle |
| addr | input | ADDR_W | Byte address; top SEC_W bits select the sector |
| din | input | BUS_W | Data bus; only bits 7:0 carry commands and program data |
| dout | output | 8 | Status bits or stored byte for the current address |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
A decoder that is stuck in the wrong step shows up at `ready`. Either busy never rises on the 4th or 6th pulse, or it rises one pulse early. The bench checks this after every single write, so the error is caught at that pulse. A wrong operation state shows up on the very next read as a wrong bit 7 or bit 2, or as a bit 6 that fails to alternate between two consecutive reads. A counter that loses or gains cycles is exposed by measuring the busy width edge by edge, and by checking that the erase still finishes after a suspend and a resume.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_PROG, ST_ERASE, ST_SUSP_RD, ST_SUSP_PROG
  } op_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PDATA, SQ_EKEY1, SQ_EKEY2, SQ_ESECT
  } seq_e;

  localparam logic [7:0] KEY_A        = 8'hAA;
  localparam logic [7:0] KEY_B        = 8'h55;
  localparam logic [7:0] OP_PROGRAM   = 8'hA0;
  localparam logic [7:0] OP_ERASE_SET = 8'h80;
  localparam logic [7:0] OP_SECTOR    = 8'h30;
  localparam logic [7:0] OP_SUSPEND   = 8'hB0;
  localparam logic [7:0] OP_RESUME    = 8'h30;
  localparam logic [7:0] ERASED_BYTE  = 8'hFF;
endpackage

// File: rtl/fsp_cmd_decoder.sv
module fsp_cmd_decoder
  import fsp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 'h555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              erase_ok,
  input  logic              wr_pulse,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  output logic              idle,
  output logic              prog_go,
  output logic              erase_go
);
  seq_e sq, sq_nxt;
  logic at_a, at_b;

  assign at_a = (addr == KEY_ADDR_A);
  assign at_b = (addr == KEY_ADDR_B);
  assign idle = (sq == SQ_IDLE);

  // any mismatch falls back to SQ_IDLE (abort, R11)
  always_comb begin
    sq_nxt   = SQ_IDLE;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    unique case (sq)
      SQ_IDLE:  if (at_a && cmd == KEY_A) sq_nxt = SQ_KEY1;
      SQ_KEY1:  if (at_b && cmd == KEY_B) sq_nxt = SQ_KEY2;
      SQ_KEY2: begin
        if (at_a && cmd == OP_PROGRAM) sq_nxt = SQ_PDATA;
        else if (at_a && cmd == OP_ERASE_SET && erase_ok) sq_nxt = SQ_EKEY1;
      end
      SQ_PDATA: prog_go = wr_pulse && en;
      SQ_EKEY1: if (at_a && cmd == KEY_A) sq_nxt = SQ_EKEY2;
      SQ_EKEY2: if (at_b && cmd == KEY_B) sq_nxt = SQ_ESECT;
      SQ_ESECT: erase_go = wr_pulse && en && (cmd == OP_SECTOR);
      default:  sq_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sq <= SQ_IDLE;
    else if (!en)      sq <= SQ_IDLE;
    else if (wr_pulse) sq <= sq_nxt;
  end

  assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go, erase_go}));
endmodule

// File: rtl/fsp_op_timer.sv
module fsp_op_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == ONE_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (load)                 cnt <= LEN_C;
    else if (run && cnt != '0)     cnt <= cnt - ONE_C;
  end

  assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/fsp_status_mux.sv
module fsp_status_mux
  import fsp_pkg::*;
(
  input  op_state_e  st,
  input  logic       pdata_b7,
  input  logic [7:0] result,
  input  logic       tog_op,
  input  logic       tog_sec,
  input  logic       in_sec,
  output logic [7:0] dout
);
  logic sec_bit;
  assign sec_bit = in_sec ? tog_sec : 1'b1;

  always_comb begin
    unique case (st)
      ST_PROG:      dout = {~pdata_b7, tog_op, 3'b000, 1'b1,    2'b00};
      ST_ERASE:     dout = {1'b0,      tog_op, 3'b000, sec_bit, 2'b00};
      ST_SUSP_PROG: dout = {~pdata_b7, tog_op, 3'b000, sec_bit, 2'b00};
      ST_SUSP_RD:   dout = in_sec ? {2'b11, 3'b000, tog_sec, 2'b00} : result;
      default:      dout = result;
    endcase
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SEC_W     = 2,
  parameter int BUS_W     = 16,
  parameter int PROG_LEN  = 40,
  parameter int ERASE_LEN = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  din,
  output logic [7:0]        dout,
  output logic              ready
);
  op_state_e        st;
  logic             we_q, oe_q, wr_pulse, rd_evt;
  logic [7:0]       cmd, pdata, result;
  logic [SEC_W-1:0] esec, rsec;
  logic             tog_op, tog_sec, in_sec;
  logic             dec_en, dec_idle, prog_go, erase_go;
  logic             p_load, p_run, p_done, e_load, e_run, e_done;
  logic             suspend_req, resume_req, op_toggling, sec_toggling;

  // only the low byte carries commands and program data (R12)
  assign cmd    = din[7:0];
  assign rsec   = addr[ADDR_W-1 -: SEC_W];
  assign in_sec = (rsec == esec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end
  assign wr_pulse = !ce_n && we_n && !we_q;
  assign rd_evt   = !ce_n && !oe_n && oe_q;

  assign dec_en = (st == ST_READ) || (st == ST_SUSP_RD);

  fsp_cmd_decoder #(.ADDR_W(ADDR_W)) dec_i (
    .clk(clk), .rst_n(rst_n), .en(dec_en), .erase_ok(st == ST_READ),
    .wr_pulse(wr_pulse), .addr(addr), .cmd(cmd),
    .idle(dec_idle), .prog_go(prog_go), .erase_go(erase_go)
  );

  assign suspend_req = (st == ST_ERASE) && wr_pulse && (cmd == OP_SUSPEND);
  assign resume_req  = (st == ST_SUSP_RD) && wr_pulse && (cmd == OP_RESUME) && dec_idle;

  assign p_load = prog_go;
  assign p_run  = (st == ST_PROG) || (st == ST_SUSP_PROG);
  assign e_load = erase_go && (st == ST_READ);
  assign e_run  = (st == ST_ERASE);

  fsp_op_timer #(.LEN(PROG_LEN)) prog_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(p_load), .run(p_run), .done(p_done)
  );
  fsp_op_timer #(.LEN(ERASE_LEN)) erase_tmr_i (
    .clk(clk), .rst_n(rst_n), .load(e_load), .run(e_run), .done(e_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_READ;
      pdata  <= '0;
      esec   <= '0;
      result <= ERASED_BYTE;
    end else begin
      unique case (st)
        ST_READ: begin
          if (prog_go) begin
            st    <= ST_PROG;
            pdata <= cmd;
          end else if (erase_go) begin
            st   <= ST_ERASE;
            esec <= rsec;
          end
        end
        ST_PROG: if (p_done) begin
          st     <= ST_READ;
          result <= pdata;
        end
        ST_ERASE: begin
          if (e_done) begin
            st     <= ST_READ;
            result <= ERASED_BYTE;
          end else if (suspend_req) begin
            st <= ST_SUSP_RD;
          end
        end
        ST_SUSP_RD: begin
          if (prog_go) begin
            st    <= ST_SUSP_PROG;
            pdata <= cmd;
          end else if (resume_req) begin
            st <= ST_ERASE;
          end
        end
        ST_SUSP_PROG: if (p_done) begin
          st     <= ST_SUSP_RD;
          result <= pdata;
        end
        default: st <= ST_READ;
      endcase
    end
  end

  assign op_toggling  = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_SUSP_PROG);
  assign sec_toggling = ((st == ST_ERASE) || (st == ST_SUSP_RD) || (st == ST_SUSP_PROG)) && in_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_op  <= 1'b0;
      tog_sec <= 1'b0;
    end else if (rd_evt) begin
      if (op_toggling)  tog_op  <= ~tog_op;
      if (sec_toggling) tog_sec <= ~tog_sec;
    end
  end

  fsp_status_mux mux_i (
    .st(st), .pdata_b7(pdata[7]), .result(result), .tog_op(tog_op),
    .tog_sec(tog_sec), .in_sec(in_sec), .dout(dout)
  );

  assign ready = rst_n && !op_toggling;

  assert_busy_after_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ && prog_go) |=> !ready);
  assert_prog_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG) |=> (st == ST_PROG || st == ST_READ));
  assert_suspend_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_req && !e_done) |=> ready);
  assert_op_toggle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SUSP_RD && rd_evt) |=> $stable(tog_op));
  assert_resume_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> !ready);
endmodule

// File: tb/flash_status_poller_tb.sv
`timescale 1ns/1ps
module flash_status_poller_tb_top;
  localparam int PROG_LEN  = 40;
  localparam int ERASE_LEN = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] din = '0;
  logic [7:0]  dout;
  logic        ready;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_status_poller #(.PROG_LEN(PROG_LEN), .ERASE_LEN(ERASE_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .ready(ready)
  );

  // row: {exp_ready, hi_byte[7:0], data[7:0], addr[11:0]}
  localparam logic [28:0] VEC [9] = '{
    {1'b1, 8'h00, 8'hAA, 12'h555},
    {1'b1, 8'h00, 8'h55, 12'h2AA},
    {1'b1, 8'h00, 8'h77, 12'h555},  // wrong opcode: abort (R11)
    {1'b1, 8'h00, 8'hA0, 12'h555},  // lone opcode, not a sequence (R11)
    {1'b1, 8'h00, 8'h5A, 12'h123},  // must not program (R11)
    {1'b1, 8'hFF, 8'hAA, 12'h555},  // upper byte junk (R12)
    {1'b1, 8'hAA, 8'h55, 12'h2AA},
    {1'b1, 8'h5A, 8'hA0, 12'h555},
    {1'b0, 8'h3C, 8'hC3, 12'h234}   // 4th pulse: busy (R2)
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic [7:0] hi);
    @(negedge clk);
    ce_n = 1'b0; addr = a; din = {hi, d}; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    @(negedge clk);
    ce_n = 1'b0; addr = a; oe_n = 1'b0;
    @(negedge clk);
    v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prog_seq(input logic [11:0] a, input logic [7:0] d);
    wr(12'h555, 8'hAA, 8'h00);
    wr(12'h2AA, 8'h55, 8'h00);
    wr(12'h555, 8'hA0, 8'h00);
    wr(a, d, 8'h00);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL R13 watchdog actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, c;
    int n;
    // R1: busy during reset, ready and erased result after
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 busy in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
    rd(12'h100, a);
    chk(a == 8'hFF, "R1 result after reset", a, 8'hFF);

    // table: abort, upper-byte masking, program start
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][11:0], VEC[i][19:12], VEC[i][27:20]);
      chk(ready == VEC[i][28], $sformatf("R2/R11/R12 row %0d", i), ready, VEC[i][28]);
    end

    // R3, R4 during program of 0xC3
    rd(12'h234, a);
    rd(12'h234, b);
    chk(a[7] == 1'b0, "R3 poll bit inverted", a[7], 0);
    chk(a[2] == 1'b1, "R3 bit2 during program", a[2], 1);
    chk(a[6] != b[6], "R4 bit6 toggles in program", b[6], !a[6]);
    wait_ready();
    rd(12'h234, a);
    chk(a == 8'hC3, "R3 data after program", a, 8'hC3);

    // R7: sequences during busy are ignored
    prog_seq(12'h300, 8'h11);
    wr(12'h555, 8'hAA, 8'h00); wr(12'h2AA, 8'h55, 8'h00); wr(12'h555, 8'h80, 8'h00);
    wr(12'h555, 8'hAA, 8'h00); wr(12'h2AA, 8'h55, 8'h00); wr(12'h400, 8'h30, 8'h00);
    prog_seq(12'h300, 8'h99);
    wait_ready();
    rd(12'h300, a);
    chk(a == 8'h11, "R7 original data kept", a, 8'h11);
    repeat (5) @(negedge clk);
    chk(ready == 1'b1, "R7 no new operation", ready, 1);

    // R13: exact busy width
    prog_seq(12'h010, 8'h80);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk(n == PROG_LEN, "R13 busy width", n, PROG_LEN);

    // R5: erase sector 1
    wr(12'h555, 8'hAA, 8'h00); wr(12'h2AA, 8'h55, 8'h00); wr(12'h555, 8'h80, 8'h00);
    wr(12'h555, 8'hAA, 8'h00); wr(12'h2AA, 8'h55, 8'h00);
    chk(ready == 1'b1, "R5 not busy after 5th", ready, 1);
    wr(12'h480, 8'h30, 8'h00);
    chk(ready == 1'b0, "R5 busy after 6th", ready, 0);
    rd(12'h480, a);
    rd(12'h4F0, b);
    chk(a[7] == 1'b0, "R5 bit7 zero in erase", a[7], 0);
    chk(a[2] != b[2], "R6 bit2 toggles in sector", b[2], !a[2]);
    chk(a[6] != b[6], "R4 bit6 toggles in erase", b[6], !a[6]);
    rd(12'h800, c);
    chk(c[2] == 1'b1, "R6 bit2 other sector", c[2], 1);

    // R8: suspend
    wr(12'h000, 8'hB0, 8'h00);
    chk(ready == 1'b1, "R8 ready in suspend", ready, 1);
    rd(12'h480, a);
    rd(12'h480, b);
    chk(a[7:6] == 2'b11 && b[7:6] == 2'b11, "R8 bits7:6 in suspended sector", {a[7:6], b[7:6]}, 4'hF);
    chk(a[2] != b[2], "R8 bit2 toggles suspended", b[2], !a[2]);
    rd(12'h010, c);
    chk(c == 8'h80, "R8 other sector result", c, 8'h80);

    // R9: program during suspend
    prog_seq(12'hC10, 8'h5A);
    chk(ready == 1'b0, "R9 busy in suspend program", ready, 0);
    rd(12'hC10, a);
    chk(a[7] == 1'b1 && a[2] == 1'b1, "R9 poll and bit2", {a[7], a[2]}, 2'b11);
    wait_ready();
    rd(12'h480, b);
    chk(b[7:6] == 2'b11, "R9 back to suspend read", b[7:6], 2'b11);
    rd(12'hC10, c);
    chk(c == 8'h5A, "R9 stored byte", c, 8'h5A);

    // R10: resume
    wr(12'h7FF, 8'h30, 8'h00);
    chk(ready == 1'b0, "R10 busy after resume", ready, 0);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk(n > 0 && n < ERASE_LEN, "R10 remaining erase cycles", n, ERASE_LEN);
    rd(12'h480, a);
    chk(a == 8'hFF, "R10 erased result", a, 8'hFF);

    // R1: reset during a program
    prog_seq(12'h020, 8'h33);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R1 busy while reset held", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 read mode after reset", ready, 1);
    rd(12'h020, a);
    chk(a == 8'hFF, "R1 no program after reset", a, 8'hFF);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule